// File: doc/BRIEF.md
# Buffered I2C Master Transfer Engine

This block is the master side of an I2C bus. It sends and receives short bursts of bytes. A host gives it one command at a time. A command carries a direction, a byte count of one to four, up to four bytes of transmit data, and two sequencing flags. The engine produces the start condition, the address byte with the direction bit, the data bytes with their acknowledge bits, and the stop condition. It drives the open-drain clock and data lines by pulling them low and reads back the wired data level.

A long transaction, or a write of a register index followed by a read, is built from a series of short commands. A command with the chain flag set ends without a stop. The engine then holds the clock low and waits. The next command either continues with more data bytes or, if its repeated-start flag is set, issues a repeated start and a fresh address byte that carries the new direction. Completion and the causes of failure are recorded in sticky status bits, each cleared by writing a one. The speed of the serial clock comes from a divisor input and a fast-mode select.

Top module: `i2c_burst_master`

## Requirements
- R1: Out of reset, both lines are released (`scl_pull`=0, `sda_pull`=0), `pending` is 0, `data_avail` is 0 and all `stat` bits are 0.
- R2: A `cmd_go` on an idle engine produces a start and then the address byte {`taddr`,`cmd_read`}. A write command then sends `cmd_len`+1 bytes, where byte i is `cmd_wdata[8i+7:8i]` and byte 0 goes first. Every byte is sent MSB first. `pending` is 1 from the clock after `cmd_go` until the command ends.
- R3: A command without the chain flag ends with a stop, then sets `stat[0]` (stop done). If a clear and a set of a status bit fall in the same cycle, the set wins.
- R4: A chained command ends with no stop. `pending` drops to 0 and `scl_pull` stays 1. A following command with `cmd_rstart`=0 sends its bytes at once, with no start and no address byte.
- R5: A command with `cmd_rstart`=1 issued on a held bus begins with a repeated start and the address byte with its own direction bit.
- R6: A read command stores received byte i in `rx_data[8i+7:8i]`. The engine acknowledges every byte except the final byte of an unchained command, which it does not acknowledge. `data_avail` rises when the read completes and is cleared by the next accepted command or by `flush`.
- R7: A not-acknowledge on the address byte or on a written byte sets `stat[2]` (incomplete), ends the command with a stop, and clears `pending`.
- R8: If the engine releases SDA while sending and samples it low with SCL high, it sets `stat[1]` (lost arbitration), releases both lines, clears `pending` and sends no stop.
- R9: `flush` while a command is pending sets `stat[3]` (aborted) and ends the command with a stop. `flush` always clears `rx_data` and `data_avail`.
- R10: A `cmd_go` while `pending` is 1 has no effect on the transfer in progress.
- R11: One SCL period lasts 4·(`clk_div`+1)·Q clocks, where Q is FAST_QTR when `fast_mode`=1 and STD_QTR otherwise.
- R12: A one in `clr_stat[k]` clears `stat[k]`. `err` is the OR of `stat[3:1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| taddr | input | 7 | 7-bit target address |
| clk_div | input | DIV_W | Divisor for the serial clock |
| fast_mode | input | 1 | Selects the fast quarter-bit scale |
| cmd_go | input | 1 | Launch-command strobe |
| cmd_read | input | 1 | Direction: 1 = read |
| cmd_chain | input | 1 | Hold the bus at the end of the command, with no stop |
| cmd_rstart | input | 1 | Begin with a repeated start on a held bus |
| cmd_len | input | LEN_W | Byte count minus one |
| cmd_wdata | input | 8·BUF_BYTES | Transmit bytes, byte 0 in the low bits |
| flush | input | 1 | Empty the buffer; abort a pending command |
| clr_stat | input | 4 | Write-one-to-clear for `stat` |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_pull | output | 1 | 1 = pull SCL low |
| sda_pull | output | 1 | 1 = pull SDA low |
| pending | output | 1 | A command is in progress |
| data_avail | output | 1 | Received bytes are valid |
| rx_data | output | 8·BUF_BYTES | Received bytes |
| stat | output | 4 | Sticky bits: 0 stop done, 1 lost arbitration, 2 incomplete, 3 aborted |
| err | output | 1 | Any error bit of `stat` is set |

## Verification
The engine setting the stop-done bit and the host clearing it can fall in the same clock edge. The bench provokes this by holding `clr_stat[0]` high on every cycle in which it sees the bit low, through the whole transfer. The bit can then only be seen as set if the set won on the edge where the stop finished, so reading 1 after the transfer proves the priority. A flush can likewise land in the middle of a byte. The bench checks that the aborted bit is set and that a stop follows on the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int BUF_BYTES = 4;
    localparam int LEN_W     = $clog2(BUF_BYTES);
    localparam int NSTAT     = 4;
    localparam int SB_STOP   = 0;
    localparam int SB_LOST   = 1;
    localparam int SB_INCOMP = 2;
    localparam int SB_ABORT  = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_STOP  = 3'd4,
        ST_HOLD  = 3'd5
    } eng_state_e;

    typedef struct packed {
        eng_state_e                 st;
        logic [1:0]                 qph;
        logic [3:0]                 bitn;
        logic [LEN_W-1:0]           idx;
        logic [LEN_W-1:0]           last;
        logic                       rd;
        logic                       chain;
        logic [7:0]                 sh;
        logic [8*BUF_BYTES-1:0]     txb;
        logic [8*BUF_BYTES-1:0]     rxb;
        logic                       avail;
        logic                       scl_lo;
        logic                       sda_lo;
    } eng_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV_W    = 8,
    parameter int STD_QTR  = 25,
    parameter int FAST_QTR = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fast,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int QMAX = (STD_QTR > FAST_QTR) ? STD_QTR : FAST_QTR;
    localparam int CW   = DIV_W + $clog2(QMAX) + 1;

    logic [CW-1:0] lim;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        lim   = (CW'(div) + CW'(1)) * (fast ? CW'(FAST_QTR) : CW'(STD_QTR));
        tick  = en && (cnt_q == lim - CW'(1));
        cnt_d = cnt_q + CW'(1);
        if (!en || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11: while idle the counter stays at zero, so each command starts on a full quarter
    p_idle_counter_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);
endmodule

// File: rtl/i2cm_sticky.sv
module i2cm_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    logic [N-1:0] q_d, q_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            q_d[i] = q_q[i];
            if (clr[i]) q_d[i] = 1'b0;
            if (set[i]) q_d[i] = 1'b1;
        end

        p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
        p_w1c_r12: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] && !set[i] |=> !q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/i2c_burst_master.sv
module i2c_burst_master
    import i2cm_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int STD_QTR  = 25,
    parameter int FAST_QTR = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [6:0]             taddr,
    input  logic [DIV_W-1:0]       clk_div,
    input  logic                   fast_mode,
    input  logic                   cmd_go,
    input  logic                   cmd_read,
    input  logic                   cmd_chain,
    input  logic                   cmd_rstart,
    input  logic [LEN_W-1:0]       cmd_len,
    input  logic [8*BUF_BYTES-1:0] cmd_wdata,
    input  logic                   flush,
    input  logic [NSTAT-1:0]       clr_stat,
    input  logic                   sda_in,
    output logic                   scl_pull,
    output logic                   sda_pull,
    output logic                   pending,
    output logic                   data_avail,
    output logic [8*BUF_BYTES-1:0] rx_data,
    output logic [NSTAT-1:0]       stat,
    output logic                   err
);
    eng_t             eng_d, eng_q;
    logic [NSTAT-1:0] stat_set;
    logic             tick;
    logic             sending, ack_bit, last_byte;
    logic [LEN_W-1:0] nxt_idx;

    assign pending = (eng_q.st != ST_IDLE) && (eng_q.st != ST_HOLD);

    i2cm_tick #(.DIV_W(DIV_W), .STD_QTR(STD_QTR), .FAST_QTR(FAST_QTR)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(pending), .fast(fast_mode),
        .div(clk_div), .tick(tick)
    );

    i2cm_sticky #(.N(NSTAT)) u_stat (
        .clk(clk), .rst_n(rst_n), .set(stat_set), .clr(clr_stat), .q(stat)
    );

    always_comb begin
        eng_d     = eng_q;
        stat_set  = '0;
        sending   = (eng_q.st == ST_ADDR) || !eng_q.rd;
        ack_bit   = (eng_q.bitn == 4'd8);
        last_byte = (eng_q.idx == eng_q.last);
        nxt_idx   = eng_q.idx + LEN_W'(1);

        if (flush) begin
            eng_d.rxb   = '0;
            eng_d.avail = 1'b0;
            if (pending && eng_q.st != ST_STOP) begin
                stat_set[SB_ABORT] = 1'b1;
                eng_d.st  = ST_STOP;
                eng_d.qph = 2'd0;
            end
        end else if (cmd_go && !pending) begin
            eng_d.txb   = cmd_wdata;
            eng_d.rd    = cmd_read;
            eng_d.chain = cmd_chain;
            eng_d.last  = cmd_len;
            eng_d.idx   = '0;
            eng_d.rxb   = '0;
            eng_d.avail = 1'b0;
            eng_d.qph   = 2'd0;
            eng_d.bitn  = 4'd0;
            if (eng_q.st == ST_HOLD && !cmd_rstart) begin
                eng_d.st = ST_DATA;
                eng_d.sh = cmd_read ? 8'h00 : cmd_wdata[7:0];
            end else begin
                eng_d.st = ST_START;
            end
        end else if (tick) begin
            eng_d.qph = eng_q.qph + 2'd1;
            unique case (eng_q.st)
                ST_START: begin
                    unique case (eng_q.qph)
                        2'd0: begin eng_d.scl_lo = 1'b1; eng_d.sda_lo = 1'b0; end
                        2'd1: eng_d.scl_lo = 1'b0;
                        2'd2: eng_d.sda_lo = 1'b1;
                        default: begin
                            eng_d.scl_lo = 1'b1;
                            eng_d.st     = ST_ADDR;
                            eng_d.bitn   = 4'd0;
                            eng_d.sh     = {taddr, eng_q.rd};
                        end
                    endcase
                end
                ST_ADDR, ST_DATA: begin
                    unique case (eng_q.qph)
                        2'd0: begin
                            if (ack_bit) eng_d.sda_lo = !sending && !(last_byte && !eng_q.chain);
                            else         eng_d.sda_lo = sending && !eng_q.sh[7];
                        end
                        2'd1: eng_d.scl_lo = 1'b0;
                        2'd2: begin
                            if (!ack_bit) begin
                                if (sending && !eng_q.sda_lo && !sda_in) begin
                                    stat_set[SB_LOST] = 1'b1;
                                    eng_d.st     = ST_IDLE;
                                    eng_d.qph    = 2'd0;
                                    eng_d.scl_lo = 1'b0;
                                    eng_d.sda_lo = 1'b0;
                                end else begin
                                    eng_d.sh = {eng_q.sh[6:0], sda_in};
                                end
                            end else if (sending && sda_in) begin
                                stat_set[SB_INCOMP] = 1'b1;
                                eng_d.st  = ST_STOP;
                                eng_d.qph = 2'd0;
                            end
                        end
                        default: begin
                            eng_d.scl_lo = 1'b1;
                            if (!ack_bit) begin
                                eng_d.bitn = eng_q.bitn + 4'd1;
                            end else begin
                                eng_d.bitn = 4'd0;
                                if (eng_q.st == ST_ADDR) begin
                                    eng_d.st  = ST_DATA;
                                    eng_d.idx = '0;
                                    eng_d.sh  = eng_q.rd ? 8'h00 : eng_q.txb[7:0];
                                end else begin
                                    if (eng_q.rd) eng_d.rxb[8*eng_q.idx +: 8] = eng_q.sh;
                                    if (last_byte) begin
                                        eng_d.avail = eng_q.rd;
                                        eng_d.st    = eng_q.chain ? ST_HOLD : ST_STOP;
                                    end else begin
                                        eng_d.idx = nxt_idx;
                                        eng_d.sh  = eng_q.txb[8*nxt_idx +: 8];
                                    end
                                end
                            end
                        end
                    endcase
                end
                ST_STOP: begin
                    unique case (eng_q.qph)
                        2'd0: begin eng_d.scl_lo = 1'b1; eng_d.sda_lo = 1'b1; end
                        2'd1: eng_d.scl_lo = 1'b0;
                        2'd2: eng_d.sda_lo = 1'b0;
                        default: begin
                            eng_d.st = ST_IDLE;
                            stat_set[SB_STOP] = 1'b1;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign scl_pull   = eng_q.scl_lo;
    assign sda_pull   = eng_q.sda_lo;
    assign data_avail = eng_q.avail;
    assign rx_data    = eng_q.rxb;
    assign err        = |stat[NSTAT-1:1];

    p_go_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pending && cmd_go && !flush |=> $stable(eng_q.txb));
    p_lost_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[SB_LOST]) |-> !scl_pull && !sda_pull && !pending);
    p_stop_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[SB_STOP]) |-> !pending);
    p_hold_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.st == ST_HOLD |-> scl_pull);
    p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[SB_INCOMP]) |-> eng_q.st == ST_STOP);
endmodule

// File: tb/i2c_burst_master_tb.sv
module i2c_burst_master_tb;
    import i2cm_pkg::*;

    localparam logic [6:0] TADDR = 7'h52;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [6:0]  taddr;
    logic [7:0]  clk_div;
    logic        fast_mode, cmd_go, cmd_read, cmd_chain, cmd_rstart, flush;
    logic [1:0]  cmd_len;
    logic [31:0] cmd_wdata;
    logic [3:0]  clr_stat;
    logic        scl_pull, sda_pull, pending, data_avail, err;
    logic [31:0] rx_data;
    logic [3:0]  stat;
    logic        tpull = 1'b0;
    logic        arb_pull;
    wire         sda_line = !(sda_pull | tpull | arb_pull);
    wire         scl_line = !scl_pull;

    i2c_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .taddr(taddr), .clk_div(clk_div),
        .fast_mode(fast_mode), .cmd_go(cmd_go), .cmd_read(cmd_read),
        .cmd_chain(cmd_chain), .cmd_rstart(cmd_rstart), .cmd_len(cmd_len),
        .cmd_wdata(cmd_wdata), .flush(flush), .clr_stat(clr_stat),
        .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .pending(pending), .data_avail(data_avail), .rx_data(rx_data),
        .stat(stat), .err(err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rdpat(input int n);
        return 8'hC3 ^ 8'(n * 37);
    endfunction

    // bus target model: 0 idle, 1 address, 2 write data, 3 read data, 4 ignore
    int          tst = 0, bitc = 0, nack_at = -1;
    logic [7:0]  tsh = 8'h00, cur = 8'h00;
    logic        trw = 1'b0, macked = 1'b0, scl_prev = 1'b1, sda_prev = 1'b1;
    logic [6:0]  tgt_addr;
    logic        clr_req = 1'b0;
    logic [7:0]  wr_log [16];
    logic [7:0]  addr_log [4];
    logic        rack_log [16];
    int          wr_n = 0, addr_n = 0, rd_n = 0, starts = 0, stops = 0;

    always @(negedge clk) begin
        if (clr_req) begin
            wr_n = 0; addr_n = 0; rd_n = 0; starts = 0; stops = 0;
            tst = 0; tpull = 1'b0; bitc = 0;
        end else if (scl_prev && scl_line && sda_prev && !sda_line) begin
            starts++; tst = 1; bitc = 0; tpull = 1'b0;
        end else if (scl_prev && scl_line && !sda_prev && sda_line) begin
            stops++; tst = 0; tpull = 1'b0;
        end else if (!scl_prev && scl_line) begin
            bitc++;
            if ((tst == 1 || tst == 2) && bitc <= 8) tsh = {tsh[6:0], sda_line};
            if (tst == 3 && bitc == 9) begin
                macked = !sda_line;
                rack_log[rd_n] = !sda_line;
                rd_n++;
            end
        end else if (scl_prev && !scl_line) begin
            cur = rdpat(rd_n);
            case (tst)
                1: if (bitc == 8) begin
                       addr_log[addr_n] = tsh; addr_n++;
                       trw = tsh[0];
                       if (tsh[7:1] == tgt_addr) tpull = 1'b1;
                       else begin tpull = 1'b0; tst = 4; end
                   end else if (bitc == 9) begin
                       bitc = 0;
                       if (trw) begin tst = 3; tpull = !cur[7]; end
                       else begin tst = 2; tpull = 1'b0; end
                   end
                2: if (bitc == 8) begin
                       wr_log[wr_n] = tsh;
                       tpull = (wr_n != nack_at);
                       wr_n++;
                   end else if (bitc == 9) begin
                       tpull = 1'b0; bitc = 0;
                   end
                3: if (bitc >= 1 && bitc <= 7) tpull = !cur[7-bitc];
                   else if (bitc == 8) tpull = 1'b0;
                   else if (bitc == 9) begin
                       bitc = 0;
                       if (macked) tpull = !cur[7];
                       else begin tpull = 1'b0; tst = 4; end
                   end
                default: ;
            endcase
        end
        scl_prev = scl_line;
        sda_prev = sda_line;
    end

    task automatic tgt_clear();
        clr_req = 1'b1;
        @(negedge clk); @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic launch(input logic rd, input logic ch, input logic rs,
                          input int len, input logic [31:0] wd);
        @(negedge clk);
        cmd_read = rd; cmd_chain = ch; cmd_rstart = rs;
        cmd_len = 2'(len - 1); cmd_wdata = wd; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_idle();
        while (pending) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_cmd(input logic rd, input logic ch, input logic rs,
                          input int len, input logic [31:0] wd);
        launch(rd, ch, rs, len, wd);
        wait_idle();
    endtask

    task automatic clear_all();
        @(negedge clk); clr_stat = 4'hF;
        @(negedge clk); clr_stat = 4'h0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
        finish_run();
    end

    int period, nr, cyc, t2;
    logic [31:0] wd;
    logic lastscl;

    initial begin
        rst_n = 1'b0; taddr = TADDR; tgt_addr = TADDR; clk_div = 8'd0; fast_mode = 1'b1;
        cmd_go = 0; cmd_read = 0; cmd_chain = 0; cmd_rstart = 0; cmd_len = 0;
        cmd_wdata = 0; flush = 0; clr_stat = 0; arb_pull = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!scl_pull && !sda_pull, "R1 lines", {scl_pull, sda_pull}, 0);
        chk(!pending && !data_avail, "R1 pending/avail", {pending, data_avail}, 0);
        chk(stat == 4'h0 && !err, "R1 status", stat, 0);

        // R2/R3 write sweep over every byte count
        for (int len = 1; len <= 4; len++) begin
            tgt_clear(); clear_all();
            wd = 32'h9E3779B9 ^ (32'h01010101 * len);
            do_cmd(1'b0, 1'b0, 1'b0, len, wd);
            chk(addr_log[0] == {TADDR, 1'b0}, "R2 address byte", addr_log[0], {TADDR, 1'b0});
            chk(wr_n == len, "R2 byte count", wr_n, len);
            for (int i = 0; i < len; i++)
                chk(wr_log[i] == wd[8*i +: 8], "R2 data byte", wr_log[i], wd[8*i +: 8]);
            chk(starts == 1 && stops == 1, "R3 start/stop", starts * 16 + stops, 17);
            chk(stat == 4'b0001 && !err, "R3 stop done", stat, 1);
        end
        clear_all();
        chk(stat == 4'h0, "R12 clear stop done", stat, 0);

        // R6 read sweep
        for (int len = 1; len <= 4; len++) begin
            tgt_clear();
            do_cmd(1'b1, 1'b0, 1'b0, len, 32'h0);
            chk(addr_log[0] == {TADDR, 1'b1}, "R6 read address", addr_log[0], {TADDR, 1'b1});
            chk(data_avail, "R6 data_avail", data_avail, 1);
            for (int i = 0; i < len; i++) begin
                chk(rx_data[8*i +: 8] == rdpat(i), "R6 rx byte", rx_data[8*i +: 8], rdpat(i));
                chk(rack_log[i] == (i != len - 1), "R6 ack pattern", rack_log[i], i != len - 1);
            end
            chk(stops == 1, "R6 stop after read", stops, 1);
        end
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
        chk(!data_avail && rx_data == 0, "R9 flush clears buffer", rx_data, 0);
        chk(stat[3] == 1'b0, "R9 flush idle no abort", stat, 1);

        // R4 chain with continuation
        tgt_clear(); clear_all();
        do_cmd(1'b0, 1'b1, 1'b0, 2, 32'h0000_2211);
        chk(!pending && scl_pull, "R4 bus held", {pending, scl_pull}, 1);
        chk(stops == 0 && stat[0] == 1'b0, "R4 no stop", stops, 0);
        do_cmd(1'b0, 1'b0, 1'b0, 1, 32'h0000_0033);
        chk(wr_n == 3 && wr_log[2] == 8'h33, "R4 continuation byte", wr_log[2], 8'h33);
        chk(starts == 1 && addr_n == 1 && stops == 1, "R4 single frame", starts * 16 + addr_n, 17);

        // R5 write then read through repeated start
        tgt_clear();
        do_cmd(1'b0, 1'b1, 1'b0, 1, 32'h0000_0007);
        do_cmd(1'b1, 1'b0, 1'b1, 2, 32'h0);
        chk(starts == 2 && stops == 1, "R5 repeated start", starts * 16 + stops, 33);
        chk(addr_log[1] == {TADDR, 1'b1}, "R5 second address", addr_log[1], {TADDR, 1'b1});
        chk(rx_data[15:0] == {rdpat(1), rdpat(0)}, "R5 read data", rx_data[15:0], {rdpat(1), rdpat(0)});

        // R7 address not acknowledged
        tgt_clear(); clear_all();
        tgt_addr = 7'h11;
        do_cmd(1'b0, 1'b0, 1'b0, 2, 32'h0000_AAAA);
        chk(stat == 4'b0101 && err, "R7 address nack status", stat, 4'b0101);
        chk(stops == 1 && wr_n == 0 && !pending, "R7 stop issued", stops, 1);
        tgt_addr = TADDR;
        clear_all();
        chk(stat == 4'h0 && !err, "R12 clear errors", stat, 0);

        // R7 data byte not acknowledged
        tgt_clear(); nack_at = 1;
        do_cmd(1'b0, 1'b0, 1'b0, 3, 32'h0077_6655);
        nack_at = -1;
        chk(wr_n == 2 && stat[2], "R7 data nack", wr_n, 2);
        chk(stops == 1, "R7 data nack stop", stops, 1);

        // R8 lost arbitration
        tgt_clear(); clear_all();
        launch(1'b0, 1'b0, 1'b0, 1, 32'h0000_00FF);
        while (!(scl_pull && sda_pull)) @(negedge clk);
        arb_pull = 1'b1;
        wait_idle();
        chk(stat == 4'b0010 && err, "R8 lost flag", stat, 4'b0010);
        chk(!scl_pull && !sda_pull, "R8 lines released", {scl_pull, sda_pull}, 0);
        arb_pull = 1'b0;
        repeat (3) @(negedge clk);

        // R9 abort by flush mid transfer
        tgt_clear(); clear_all();
        launch(1'b0, 1'b0, 1'b0, 4, 32'h1234_5678);
        repeat (60) @(negedge clk);
        flush = 1'b1; @(negedge clk); flush = 1'b0;
        wait_idle();
        chk(stat == 4'b1001 && err, "R9 aborted with stop", stat, 4'b1001);
        chk(stops == 1 && !pending, "R9 stop on bus", stops, 1);

        // R10 second command while pending
        tgt_clear(); clear_all();
        launch(1'b0, 1'b0, 1'b0, 1, 32'h0000_0011);
        repeat (30) @(negedge clk);
        launch(1'b0, 1'b0, 1'b0, 3, 32'hAABB_CCDD);
        wait_idle();
        chk(wr_n == 1 && wr_log[0] == 8'h11, "R10 ignored go", wr_log[0], 8'h11);
        chk(starts == 1, "R10 one frame", starts, 1);

        // R3 set and clear in the same cycle
        tgt_clear(); clear_all();
        launch(1'b0, 1'b0, 1'b0, 1, 32'h0000_0042);
        while (pending) begin
            clr_stat[0] = !stat[0];
            @(negedge clk);
        end
        clr_stat[0] = 1'b0;
        @(negedge clk);
        chk(stat[0] == 1'b1, "R3 set wins over clear", stat, 1);

        // R11 clock period, fast and standard
        for (int m = 0; m < 2; m++) begin
            tgt_clear();
            fast_mode = (m == 0);
            clk_div = (m == 0) ? 8'd1 : 8'd0;
            launch(1'b0, 1'b0, 1'b0, 1, 32'h0000_0001);
            nr = 0; cyc = 0; t2 = 0; lastscl = scl_line;
            while (nr < 3) begin
                @(negedge clk); cyc++;
                if (scl_line && !lastscl) begin
                    nr++;
                    if (nr == 2) t2 = cyc;
                end
                lastscl = scl_line;
            end
            period = cyc - t2;
            chk(period == ((m == 0) ? 48 : 100), "R11 SCL period", period, (m == 0) ? 48 : 100);
            wait_idle();
        end

        finish_run();
    end
endmodule